// File: doc/BRIEF.md
# Radio Supply Rail Sequencer

The sequencer brings up the three supply domains of a PoE-powered radio unit in a fixed order once the powered-device front end reports good input power. The management domain comes up first, the analog/PLL domain second and the high-power amplifier domain last. Each enable waits for the preceding domain's power-good, and each step has a bounded wait. After the last domain is good and has stayed good for a settle interval, the system reset output is released.

While the rails are coming up or running, the block watches every rail that has already reported good, and it watches the input power. Any loss is a fault. On a fault it records a cause code and the cycle stamp of the fault. It then turns the rails off in reverse order with fixed spacing, waits out a backoff interval and tries again. The retry count only grows until a clear command arrives, so a unit that keeps browning out ends in a latched-off state rather than cycling forever.

Top module: `poe_rail_sequencer`

## Requirements
- R1: After reset all enables are low, `sys_rst_n` is low, `fault_code` and `retry_cnt` are 0 and `latched_off` is 0; nothing is enabled while `pd_pgood` is low, and `en_mgmt` rises one cycle after `pd_pgood` is sampled high.
- R2: `en_ana` rises only after `mgmt_pg` was sampled high, and `en_pa` only after `ana_pg` was sampled high; `en_pa` high implies `en_ana` high, which implies `en_mgmt` high.
- R3: If the rail being brought up does not report power-good within STAGE_TIMEOUT cycles of its enable, the block raises a fault with code 1 (management), 2 (analog) or 3 (PA), and `fault_code` shows it STAGE_TIMEOUT cycles after the enable appears.
- R4: `sys_rst_n` rises exactly SETTLE_CYCLES cycles after the cycle in which `pa_pg` is first sampled high, and only while all rails and `pd_pgood` are good.
- R5: A rail that has already reported good and then drops, during bring-up or run, raises code 4 (management), 5 (analog) or 6 (PA); loss of `pd_pgood` raises code 7. Code 7 takes precedence over any drop, and among simultaneous drops the lower rail wins (management before analog before PA).
- R6: On a fault, `en_pa` and `sys_rst_n` go low at once, `en_ana` goes low OFF_GAP cycles later and `en_mgmt` OFF_GAP cycles after that.
- R7: `fault_stamp` holds the value of a free-running cycle counter, 0 in the first cycle after reset, taken in the cycle the fault is detected.
- R8: If fewer than MAX_RETRIES retries have been made, `retry_cnt` increments BACKOFF_CYCLES cycles after `en_mgmt` falls, and bring-up restarts in the next cycle if `pd_pgood` is high.
- R9: A fault when `retry_cnt` equals MAX_RETRIES ends in the latched-off state: `latched_off` rises when `en_mgmt` falls, and no rail is enabled again until a clear.
- R10: `clear_i` in the latched-off state, or while running with reset released, sets `fault_code` and `retry_cnt` to 0 (and leaves latched-off); in any other state it has no effect.
- R11: A successful bring-up does not reset `retry_cnt` or `fault_code`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_pgood | input | 1 | Input power from the PoE front end is good |
| mgmt_pg | input | 1 | Management rail power-good |
| ana_pg | input | 1 | Analog/PLL rail power-good |
| pa_pg | input | 1 | PA rail power-good |
| clear_i | input | 1 | Clear latched fault and retry count |
| en_mgmt | output | 1 | Management rail enable |
| en_ana | output | 1 | Analog/PLL rail enable |
| en_pa | output | 1 | PA rail enable |
| sys_rst_n | output | 1 | System reset, active low |
| fault_code | output | 3 | Cause of the most recent fault (0 none) |
| fault_stamp | output | STAMP_W | Cycle stamp of the most recent fault |
| retry_cnt | output | clog2(MAX_RETRIES+1) | Automatic retries made since the last clear |
| latched_off | output | 1 | Retries used up, waiting for clear |

## Verification
Rails answering their enables after random delays inside the timeout show the order gating and the exact settle time before reset release. A rail that never answers, chosen at random per trial, shows which stage produced the timeout code. Drops of a random rail, or of input power, while running show the drop codes. Directed cases add simultaneous drops to show the code priority. A PA rail that never comes up, repeated until the retries are used up, shows the reverse-order shutdown spacing, backoff, retry counting, the fault stamp and lockout. Clear pulses given in lockout, in bring-up and in run show when the command acts and when it is ignored.

// File: rtl/rail_seq_pkg.sv
package rail_seq_pkg;

    localparam int RAILS = 3;
    localparam int SW    = $clog2(RAILS);

    typedef logic [2:0] fault_code_t;

    localparam fault_code_t FC_NONE    = 3'd0;
    localparam fault_code_t FC_PD_LOST = 3'd7;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_RAMP,
        ST_SETTLE,
        ST_RUN,
        ST_DOWN,
        ST_BACKOFF,
        ST_LOCK
    } seq_state_e;

    // Stage timeout codes start at 1, drop codes at 4, both indexed by rail.
    function automatic fault_code_t fc_timeout(input logic [SW-1:0] idx);
        return fault_code_t'(3'd1 + {1'b0, idx});
    endfunction

    function automatic fault_code_t fc_drop(input logic [SW-1:0] idx);
        return fault_code_t'(3'd4 + {1'b0, idx});
    endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/seq_fault_detect.sv
module seq_fault_detect
    import rail_seq_pkg::*;
(
    input  logic             active,
    input  logic             pd_ok,
    input  logic [RAILS-1:0] pg,
    input  logic [RAILS-1:0] watch,
    input  logic             ramp,
    input  logic [SW-1:0]    idx,
    input  logic             expired,
    output logic             hit,
    output fault_code_t      code
);
    logic [RAILS-1:0] drop;
    logic             ramp_pg;

    for (genvar g = 0; g < RAILS; g++) begin : g_drop
        assign drop[g] = watch[g] & ~pg[g];
    end

    always_comb begin
        ramp_pg = 1'b0;
        for (int i = 0; i < RAILS; i++) begin
            if (idx == SW'(i)) ramp_pg = pg[i];
        end
    end

    always_comb begin
        hit  = 1'b0;
        code = FC_NONE;
        if (active) begin
            if (!pd_ok) begin
                hit  = 1'b1;
                code = FC_PD_LOST;
            end else if (|drop) begin
                hit = 1'b1;
                for (int i = RAILS - 1; i >= 0; i--) begin
                    if (drop[i]) code = fc_drop(SW'(i));
                end
            end else if (ramp && expired && !ramp_pg) begin
                hit  = 1'b1;
                code = fc_timeout(idx);
            end
        end
    end
endmodule

// File: rtl/poe_rail_sequencer.sv
module poe_rail_sequencer
    import rail_seq_pkg::*;
#(
    parameter int STAGE_TIMEOUT  = 20,
    parameter int OFF_GAP        = 4,
    parameter int SETTLE_CYCLES  = 10,
    parameter int BACKOFF_CYCLES = 30,
    parameter int MAX_RETRIES    = 3,
    parameter int STAMP_W        = 16
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               pd_pgood,
    input  logic                               mgmt_pg,
    input  logic                               ana_pg,
    input  logic                               pa_pg,
    input  logic                               clear_i,
    output logic                               en_mgmt,
    output logic                               en_ana,
    output logic                               en_pa,
    output logic                               sys_rst_n,
    output logic [2:0]                         fault_code,
    output logic [STAMP_W-1:0]                 fault_stamp,
    output logic [$clog2(MAX_RETRIES+1)-1:0]   retry_cnt,
    output logic                               latched_off
);
    localparam int RW    = $clog2(MAX_RETRIES + 1);
    localparam int TMAX1 = (STAGE_TIMEOUT > OFF_GAP) ? STAGE_TIMEOUT : OFF_GAP;
    localparam int TMAX2 = (SETTLE_CYCLES > BACKOFF_CYCLES) ? SETTLE_CYCLES : BACKOFF_CYCLES;
    localparam int TMAX  = (TMAX1 > TMAX2) ? TMAX1 : TMAX2;
    localparam int TW    = $clog2(TMAX + 1);
    localparam logic [SW-1:0] TOP_RAIL = SW'(RAILS - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [SW-1:0]    stage;
        logic [RAILS-1:0] en;
        logic [RAILS-1:0] watch;
        logic             rel;
        fault_code_t      code;
        logic [STAMP_W-1:0] now;
        logic [STAMP_W-1:0] stamp;
        logic [RW-1:0]    retry;
    } seq_regs_t;

    seq_regs_t        cur_q, nxt_d;
    logic             tmr_load_d;
    logic [TW-1:0]    tmr_val_d;
    logic             tmr_expired;
    logic [RAILS-1:0] pg_vec;
    logic             flt_active;
    logic             flt_hit;
    fault_code_t      flt_code;
    logic             stage_pg;

    assign pg_vec = {pa_pg, ana_pg, mgmt_pg};

    seq_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load_d),
        .load_val (tmr_val_d),
        .expired  (tmr_expired)
    );

    assign flt_active = (cur_q.state == ST_RAMP) ||
                        (cur_q.state == ST_SETTLE) ||
                        (cur_q.state == ST_RUN);

    seq_fault_detect u_detect (
        .active  (flt_active),
        .pd_ok   (pd_pgood),
        .pg      (pg_vec),
        .watch   (cur_q.watch),
        .ramp    (cur_q.state == ST_RAMP),
        .idx     (cur_q.stage),
        .expired (tmr_expired),
        .hit     (flt_hit),
        .code    (flt_code)
    );

    always_comb begin
        stage_pg = 1'b0;
        for (int i = 0; i < RAILS; i++) begin
            if (cur_q.stage == SW'(i)) stage_pg = pg_vec[i];
        end
    end

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.now  = cur_q.now + 1'b1;
        tmr_load_d = 1'b0;
        tmr_val_d  = '0;

        if (flt_hit) begin
            // Fault: drop the top rail and reset now, record the cause.
            nxt_d.state        = ST_DOWN;
            nxt_d.en[TOP_RAIL] = 1'b0;
            nxt_d.stage        = TOP_RAIL - 1'b1;
            nxt_d.watch        = '0;
            nxt_d.rel          = 1'b0;
            nxt_d.code         = flt_code;
            nxt_d.stamp        = cur_q.now;
            tmr_load_d         = 1'b1;
            tmr_val_d          = TW'(OFF_GAP - 1);
        end else begin
            unique case (cur_q.state)
                ST_OFF: begin
                    nxt_d.en  = '0;
                    nxt_d.rel = 1'b0;
                    if (pd_pgood) begin
                        nxt_d.state = ST_RAMP;
                        nxt_d.stage = '0;
                        nxt_d.en[0] = 1'b1;
                        tmr_load_d  = 1'b1;
                        tmr_val_d   = TW'(STAGE_TIMEOUT - 1);
                    end
                end
                ST_RAMP: begin
                    if (stage_pg) begin
                        nxt_d.watch[cur_q.stage] = 1'b1;
                        tmr_load_d               = 1'b1;
                        if (cur_q.stage == TOP_RAIL) begin
                            nxt_d.state = ST_SETTLE;
                            tmr_val_d   = TW'(SETTLE_CYCLES - 1);
                        end else begin
                            nxt_d.stage              = cur_q.stage + 1'b1;
                            nxt_d.en[cur_q.stage + 1'b1] = 1'b1;
                            tmr_val_d                = TW'(STAGE_TIMEOUT - 1);
                        end
                    end
                end
                ST_SETTLE: begin
                    if (tmr_expired) begin
                        nxt_d.state = ST_RUN;
                        nxt_d.rel   = 1'b1;
                    end
                end
                ST_RUN: begin
                    if (clear_i) begin
                        nxt_d.code  = FC_NONE;
                        nxt_d.retry = '0;
                    end
                end
                ST_DOWN: begin
                    if (tmr_expired) begin
                        nxt_d.en[cur_q.stage] = 1'b0;
                        tmr_load_d            = 1'b1;
                        if (cur_q.stage == '0) begin
                            if (RW'(cur_q.retry) < RW'(MAX_RETRIES)) begin
                                nxt_d.state = ST_BACKOFF;
                                tmr_val_d   = TW'(BACKOFF_CYCLES - 1);
                            end else begin
                                nxt_d.state = ST_LOCK;
                            end
                        end else begin
                            nxt_d.stage = cur_q.stage - 1'b1;
                            tmr_val_d   = TW'(OFF_GAP - 1);
                        end
                    end
                end
                ST_BACKOFF: begin
                    if (tmr_expired) begin
                        nxt_d.retry = cur_q.retry + 1'b1;
                        nxt_d.state = ST_OFF;
                    end
                end
                ST_LOCK: begin
                    nxt_d.en = '0;
                    if (clear_i) begin
                        nxt_d.state = ST_OFF;
                        nxt_d.code  = FC_NONE;
                        nxt_d.retry = '0;
                    end
                end
                default: nxt_d.state = ST_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_OFF, stage: '0, en: '0, watch: '0, rel: 1'b0,
                       code: FC_NONE, now: '0, stamp: '0, retry: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign en_mgmt     = cur_q.en[0];
    assign en_ana      = cur_q.en[1];
    assign en_pa       = cur_q.en[2];
    assign sys_rst_n   = cur_q.rel;
    assign fault_code  = cur_q.code;
    assign fault_stamp = cur_q.stamp;
    assign retry_cnt   = cur_q.retry;
    assign latched_off = (cur_q.state == ST_LOCK);
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
    parameter int MAX_RETRIES = 3,
    parameter int STAMP_W     = 16
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             pd_pgood,
    input logic                             mgmt_pg,
    input logic                             ana_pg,
    input logic                             pa_pg,
    input logic                             en_mgmt,
    input logic                             en_ana,
    input logic                             en_pa,
    input logic                             sys_rst_n,
    input logic [2:0]                       fault_code,
    input logic [STAMP_W-1:0]               fault_stamp,
    input logic [$clog2(MAX_RETRIES+1)-1:0] retry_cnt,
    input logic                             latched_off
);
    logic unused_stamp;
    assign unused_stamp = ^fault_stamp;

    assert_mgmt_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_mgmt) |-> $past(pd_pgood));

    assert_ana_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_ana) |-> $past(mgmt_pg));

    assert_pa_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en_pa) |-> ($past(ana_pg) && $past(mgmt_pg)));

    assert_enable_nest_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_pa |-> en_ana) and (en_ana |-> en_mgmt));

    assert_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_n) |-> $past(pd_pgood && mgmt_pg && ana_pg && pa_pg));

    assert_release_rails_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_n |-> (en_mgmt && en_ana && en_pa));

    assert_run_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sys_rst_n && !pa_pg) |=> (fault_code != 3'd0));

    assert_pa_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_n) |-> !en_pa);

    assert_retry_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (retry_cnt != $past(retry_cnt)) |->
        ((int'(retry_cnt) == int'($past(retry_cnt)) + 1) || (retry_cnt == '0)));

    assert_retry_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(retry_cnt) <= MAX_RETRIES);

    assert_lock_dark_R9: assert property (@(posedge clk) disable iff (!rst_n)
        latched_off |-> (!en_mgmt && !en_ana && !en_pa));
endmodule

bind poe_rail_sequencer seq_checker #(
    .MAX_RETRIES (MAX_RETRIES),
    .STAMP_W     (STAMP_W)
) u_seq_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .pd_pgood    (pd_pgood),
    .mgmt_pg     (mgmt_pg),
    .ana_pg      (ana_pg),
    .pa_pg       (pa_pg),
    .en_mgmt     (en_mgmt),
    .en_ana      (en_ana),
    .en_pa       (en_pa),
    .sys_rst_n   (sys_rst_n),
    .fault_code  (fault_code),
    .fault_stamp (fault_stamp),
    .retry_cnt   (retry_cnt),
    .latched_off (latched_off)
);

// File: tb/tb_poe_rail_sequencer.sv
module tb_poe_rail_sequencer;
    localparam int TMO     = 20;
    localparam int GAP     = 4;
    localparam int SETTLE  = 10;
    localparam int BACK    = 30;
    localparam int MAXR    = 3;
    localparam int STW     = 16;
    localparam int NEVER   = 1 << 30;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic       rst_n, pd, clr;
    logic [2:0] pg_r;
    logic [2:0] kill;
    int         dly [3];
    int         cnt [3];
    logic       en_mgmt, en_ana, en_pa, sys_rst_n, latched_off;
    logic [2:0] fault_code;
    logic [STW-1:0] fault_stamp;
    logic [1:0] retry_cnt;

    int  n_chk = 0;
    int  n_bad = 0;
    int  cyc;
    bit  done = 1'b0;

    poe_rail_sequencer #(
        .STAGE_TIMEOUT(TMO), .OFF_GAP(GAP), .SETTLE_CYCLES(SETTLE),
        .BACKOFF_CYCLES(BACK), .MAX_RETRIES(MAXR), .STAMP_W(STW)
    ) dut (
        .clk(clk), .rst_n(rst_n), .pd_pgood(pd),
        .mgmt_pg(pg_r[0]), .ana_pg(pg_r[1]), .pa_pg(pg_r[2]), .clear_i(clr),
        .en_mgmt(en_mgmt), .en_ana(en_ana), .en_pa(en_pa), .sys_rst_n(sys_rst_n),
        .fault_code(fault_code), .fault_stamp(fault_stamp),
        .retry_cnt(retry_cnt), .latched_off(latched_off)
    );

    // Rail plant model: each rail answers its enable after dly[i] cycles.
    always @(negedge clk) begin
        logic [2:0] en_v;
        en_v = {en_pa, en_ana, en_mgmt};
        for (int i = 0; i < 3; i++) begin
            if (!rst_n || kill[i] || !en_v[i]) begin
                pg_r[i] <= 1'b0;
                cnt[i]  <= 0;
            end else if (cnt[i] >= dly[i]) begin
                pg_r[i] <= 1'b1;
            end else begin
                cnt[i] <= cnt[i] + 1;
            end
        end
    end

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // Continuous order check R2 / R4 at every sample point.
    always begin
        tick();
        if (rst_n && !done) begin
            chk("R2 pa implies ana", (en_pa && !en_ana) ? 1 : 0, 0);
            chk("R2 ana implies mgmt", (en_ana && !en_mgmt) ? 1 : 0, 0);
            chk("R4 release implies all on", (sys_rst_n && !(en_mgmt && en_ana && en_pa)) ? 1 : 0, 0);
        end
    end

    task automatic do_reset();
        rst_n = 1'b0; pd = 1'b0; clr = 1'b0; kill = 3'b000;
        for (int i = 0; i < 3; i++) dly[i] = 0;
        repeat (3) tick();
        rst_n = 1'b1;
    endtask

    task automatic wait_run(input string req, input int lim);
        int n = 0;
        while (!sys_rst_n && n < lim) begin tick(); n++; end
        chk(req, sys_rst_n, 1);
    endtask

    task automatic wait_fault(input string req, input int lim);
        int n = 0;
        while (fault_code == 3'd0 && n < lim) begin tick(); n++; end
        chk(req, (fault_code != 3'd0) ? 1 : 0, 1);
    endtask

    task automatic pulse_clear();
        clr = 1'b1;
        tick();
        clr = 1'b0;
    endtask

    initial begin
        int seed_v;
        int n;
        int k;
        int r;
        seed_v = $urandom(32'd5150);
        do_reset();

        // R1: reset state, idle while input power is absent
        chk("R1 en_mgmt", en_mgmt, 0);
        chk("R1 en_pa", en_pa, 0);
        chk("R1 sys_rst_n", sys_rst_n, 0);
        chk("R1 fault_code", fault_code, 0);
        chk("R1 retry_cnt", retry_cnt, 0);
        chk("R1 latched_off", latched_off, 0);
        repeat (20) tick();
        chk("R1 idle without pd", {en_pa, en_ana, en_mgmt}, 0);
        pd = 1'b1;
        tick();
        chk("R1 mgmt one cycle after pd", en_mgmt, 1);

        // Random trials
        for (int it = 0; it < 40; it++) begin
            do_reset();
            for (int i = 0; i < 3; i++) dly[i] = $urandom % (TMO - 2);
            k = $urandom % 4;
            r = $urandom % 3;
            if (k == 1) dly[r] = NEVER;
            pd = 1'b1;
            if (k == 0) begin
                n = 0;
                while (!pg_r[2] && n < 200) begin tick(); n++; end
                chk("R4 reset low before settle", sys_rst_n, 0);
                n = 0;
                while (!sys_rst_n && n < 200) begin tick(); n++; end
                chk("R4 settle cycles", n, SETTLE);
                chk("R11 no fault on clean start", fault_code, 0);
            end else if (k == 1) begin
                wait_fault("R3 timeout seen", 300);
                chk("R3 timeout code", fault_code, 1 + r);
            end else begin
                wait_run("R5 reached run", 300);
                repeat ($urandom % 10) tick();
                if (k == 2) kill[r] = 1'b1;
                else        pd = 1'b0;
                wait_fault("R5 drop seen", 20);
                chk("R5 drop code", fault_code, (k == 2) ? 4 + r : 7);
                chk("R6 reset low after fault", sys_rst_n, 0);
                chk("R6 pa off after fault", en_pa, 0);
            end
        end

        // R5 priority: input power loss beats rail drops
        do_reset(); pd = 1'b1;
        wait_run("R5 run before priority", 300);
        pd = 1'b0; kill = 3'b110;
        wait_fault("R5 pd priority seen", 20);
        chk("R5 pd loss wins", fault_code, 7);
        // R5 priority: lower rail wins among drops
        do_reset(); pd = 1'b1;
        wait_run("R5 run before drop pair", 300);
        kill = 3'b110;
        wait_fault("R5 pair seen", 20);
        chk("R5 analog beats PA", fault_code, 5);

        // PA rail never comes up: timing, retries, lockout
        do_reset();
        dly[0] = 2; dly[1] = 3; dly[2] = NEVER;
        pd = 1'b1;
        for (int f = 0; f <= MAXR; f++) begin
            n = 0;
            while (!en_pa && n < 400) begin tick(); n++; end
            chk("R2 pa enabled", en_pa, 1);
            n = 0;
            while (fault_code == 3'd0 && n < 100) begin tick(); n++; end
            if (f > 0) begin
                n = 0;
                while (n < TMO + 5 && fault_code == 3'd3 && en_pa) begin tick(); n++; end
            end
            if (f == 0) begin
                chk("R3 timeout cycles", n, TMO);
                chk("R7 fault stamp", fault_stamp, (cyc - 1) & ((1 << STW) - 1));
            end
            chk("R3 PA timeout code", fault_code, 3);
            chk("R6 pa off at fault", en_pa, 0);
            chk("R6 ana still on", en_ana, 1);
            n = 0;
            while (en_ana && n < 100) begin tick(); n++; end
            chk("R6 ana off gap", n, GAP);
            chk("R6 mgmt still on", en_mgmt, 1);
            n = 0;
            while (en_mgmt && n < 100) begin tick(); n++; end
            chk("R6 mgmt off gap", n, GAP);
            if (f < MAXR) begin
                n = 0;
                while (retry_cnt == 2'(f) && n < 200) begin tick(); n++; end
                chk("R8 backoff cycles", n, BACK);
                chk("R8 retry count", retry_cnt, f + 1);
                tick();
                chk("R8 restart", en_mgmt, 1);
            end else begin
                chk("R9 latched off", latched_off, 1);
                repeat (100) tick();
                chk("R9 stays dark", {en_pa, en_ana, en_mgmt}, 0);
                chk("R9 retry at limit", retry_cnt, MAXR);
                chk("R9 cause kept", fault_code, 3);
            end
        end
        // R10: clear in lockout
        dly[2] = 3;
        pulse_clear();
        chk("R10 code cleared", fault_code, 0);
        chk("R10 retry cleared", retry_cnt, 0);
        chk("R10 leaves lockout", latched_off, 0);
        wait_run("R10 runs after clear", 300);

        // R10/R11: clear ignored during bring-up, kept after success
        do_reset();
        dly[1] = NEVER;
        pd = 1'b1;
        wait_fault("R3 analog timeout seen", 300);
        chk("R3 analog timeout code", fault_code, 2);
        dly[1] = 4;
        n = 0;
        while (retry_cnt == 2'd0 && n < 300) begin tick(); n++; end
        chk("R8 first retry", retry_cnt, 1);
        n = 0;
        while (!en_ana && n < 100) begin tick(); n++; end
        pulse_clear();
        chk("R10 clear ignored retry", retry_cnt, 1);
        chk("R10 clear ignored code", fault_code, 2);
        wait_run("R11 run after retry", 300);
        chk("R11 retry kept", retry_cnt, 1);
        chk("R11 code kept", fault_code, 2);
        pulse_clear();
        chk("R10 run clear retry", retry_cnt, 0);
        chk("R10 run clear code", fault_code, 0);
        chk("R10 run continues", sys_rst_n, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule